// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block performs the byte merging for the left and right partial-word loads and stores on a little-endian memory with a word width of `DATA_W`. A request carries an effective address, one of four operations, the store source word and the target register number with its current contents. The block issues a single aligned word read. For a load, it merges the returned word with the register base value and presents the result. For a store, it merges the register into the returned word and writes that word back to the same aligned address.

The base value for a load normally comes from the current register contents. When a delayed load is still pending and targets the same register, the block takes the pending load value instead. Only one request is in flight at a time. `busy` tells the issuing pipeline when a new request is taken. A memory error at either stage ends the operation with an abort pulse, and no write follows a failed read.

Top module: `umg_merger`

## Requirements
- R1: Every memory access uses the effective address with its low two bits cleared. A store writes back to exactly the address it read.
- R2: Load-left (`req_op`=00) with byte offset o and k = 3 − o gives the following. k=0 returns the memory word. k=1, 2 and 3 keep the low 8, 16 or 24 base bits and place the memory word shifted left by 8, 16 or 24 above them.
- R3: Load-right (`req_op`=01) with k = 3 − o gives the following. k=0, 1 and 2 replace the low 8, 16 or 24 base bits with memory bits 31..24, 31..16 or 31..8. k=3 returns the memory word.
- R4: Store-left (`req_op`=10) with k = 3 − o writes the following. k=0 writes the register. k=1, 2 and 3 keep the top 8, 16 or 24 memory bits and fill the remainder with the register shifted right by 8, 16 or 24.
- R5: Store-right (`req_op`=11) with k = 3 − o writes the following. k=3 writes the register. k=0, 1 and 2 keep the low 24, 16 or 8 memory bits and place the register shifted left by 24, 16 or 8 above them.
- R6: The load base is `pend_value` when `pend_valid` is 1 and `pend_reg` equals `req_reg`. Otherwise it is `req_base`.
- R7: A load makes exactly one read and no write. A store makes exactly one read followed by exactly one write. Read and write strobes are never high together.
- R8: A memory error on the read raises `op_abort` for one cycle. It produces no write and no `ld_valid`.
- R9: `ld_valid` or `st_done` pulses for exactly one cycle when the operation completes. `req_valid` is ignored while `busy` is high. A memory strobe stays high with a stable address until it is acknowledged.
- R10: After reset, `busy`, both memory strobes, `ld_valid`, `st_done` and `op_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| req_addr | input | ADDR_W | Effective byte address |
| req_data | input | DATA_W | Store source register value |
| req_reg | input | IDX_W | Load target register number |
| req_base | input | DATA_W | Current contents of the load target register |
| pend_valid | input | 1 | A delayed load is still pending |
| pend_reg | input | IDX_W | Target register of the pending load |
| pend_value | input | DATA_W | Value of the pending load |
| busy | output | 1 | Operation in progress |
| mem_rd_en | output | 1 | Aligned word read strobe |
| mem_wr_en | output | 1 | Aligned word write strobe |
| mem_addr | output | ADDR_W | Aligned word address |
| mem_wdata | output | DATA_W | Merged word to write |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| ld_valid | output | 1 | Merged load result valid (one cycle) |
| ld_data | output | DATA_W | Merged load result |
| st_done | output | 1 | Store write-back completed (one cycle) |
| op_abort | output | 1 | Operation aborted by a memory error (one cycle) |

## Verification
The bench memory acknowledges one cycle after it sees a strobe. With that timing, a load result or a read abort arrives two clock edges after the accepting edge, and a store completion arrives four edges after it. The driver records the cycle number at acceptance next to each expected item in the scoreboard. The monitor samples on the falling edge and checks the elapsed count along with the data, the read and write counts and the address. An early, late or missing result therefore fails its own check and does not get matched against a later item.

// File: rtl/umg_pkg.sv
package umg_pkg;

   typedef enum logic [1:0] {
      UMG_LD_LEFT  = 2'b00,
      UMG_LD_RIGHT = 2'b01,
      UMG_ST_LEFT  = 2'b10,
      UMG_ST_RIGHT = 2'b11
   } umg_op_e;

   typedef enum logic [1:0] {
      UMG_IDLE  = 2'b00,
      UMG_READ  = 2'b01,
      UMG_WRITE = 2'b10
   } umg_state_e;

   function automatic logic umg_is_store(input umg_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/umg_base_select.sv
module umg_base_select #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              pend_valid,
   input  logic [IDX_W-1:0]  pend_reg,
   input  logic [DATA_W-1:0] pend_value,
   input  logic [IDX_W-1:0]  tgt_reg,
   input  logic [DATA_W-1:0] tgt_value,
   output logic [DATA_W-1:0] base
);

   logic hit;

   always_comb begin
      hit  = pend_valid && (pend_reg == tgt_reg);
      base = hit ? pend_value : tgt_value;
   end

endmodule

// File: rtl/umg_merge.sv
module umg_merge
   import umg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTES  = DATA_W / 8,
   parameter int OFS_W  = $clog2(BYTES)
) (
   input  umg_op_e           op,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] mem_word,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] merged
);

   localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

   logic [DATA_W-1:0] ll_c [BYTES];
   logic [DATA_W-1:0] lr_c [BYTES];
   logic [DATA_W-1:0] sl_c [BYTES];
   logic [DATA_W-1:0] sr_c [BYTES];
   logic [OFS_W-1:0]  k_sel;

   for (genvar k = 0; k < BYTES; k++) begin : g_case
      localparam int KB  = 8 * k;
      localparam int RB  = 8 * (k + 1);
      localparam int SRB = 8 * (BYTES - 1 - k);
      localparam logic [DATA_W-1:0] KEEP_LO_K  = ONES >> (DATA_W - KB);
      localparam logic [DATA_W-1:0] KEEP_LO_R  = ONES >> (DATA_W - RB);
      localparam logic [DATA_W-1:0] KEEP_HI_K  = ~(ONES >> KB);
      localparam logic [DATA_W-1:0] KEEP_LO_SR = ONES >> (DATA_W - SRB);

      always_comb begin
         ll_c[k] = (mem_word << KB) | (opnd & KEEP_LO_K);
         lr_c[k] = (opnd & ~KEEP_LO_R) | (mem_word >> (DATA_W - RB));
         sl_c[k] = (mem_word & KEEP_HI_K) | (opnd >> KB);
         sr_c[k] = (mem_word & KEEP_LO_SR) | (opnd << SRB);
      end
   end

   always_comb begin
      k_sel = OFS_W'(BYTES - 1) - ofs;
      unique case (op)
         UMG_LD_LEFT:  merged = ll_c[k_sel];
         UMG_LD_RIGHT: merged = lr_c[k_sel];
         UMG_ST_LEFT:  merged = sl_c[k_sel];
         default:      merged = sr_c[k_sel];
      endcase
   end

endmodule

// File: rtl/umg_ctrl.sv
module umg_ctrl
   import umg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_store,
   input  logic mem_ack,
   input  logic mem_err,
   output logic accept,
   output logic rd_take,
   output logic busy,
   output logic rd_en,
   output logic wr_en,
   output logic ld_fin,
   output logic st_fin,
   output logic abort_fin
);

   umg_state_e state_q, state_d;
   logic       store_q;

   always_comb begin
      accept  = req_valid && (state_q == UMG_IDLE);
      rd_en   = (state_q == UMG_READ);
      wr_en   = (state_q == UMG_WRITE);
      busy    = (state_q != UMG_IDLE);
      rd_take = rd_en && mem_ack && !mem_err;
      state_d = state_q;
      unique case (state_q)
         UMG_IDLE:  if (accept) state_d = UMG_READ;
         UMG_READ:  if (mem_err) state_d = UMG_IDLE;
                    else if (mem_ack) state_d = store_q ? UMG_WRITE : UMG_IDLE;
         UMG_WRITE: if (mem_err || mem_ack) state_d = UMG_IDLE;
         default:   state_d = UMG_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= UMG_IDLE;
         store_q   <= 1'b0;
         ld_fin    <= 1'b0;
         st_fin    <= 1'b0;
         abort_fin <= 1'b0;
      end else begin
         state_q   <= state_d;
         if (accept) store_q <= req_store;
         ld_fin    <= rd_take && !store_q;
         st_fin    <= wr_en && mem_ack && !mem_err;
         abort_fin <= (rd_en || wr_en) && mem_err;
      end
   end

   assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));

   assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_fin, st_fin, abort_fin}));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fin || st_fin) |=> !(ld_fin || st_fin));

endmodule

// File: rtl/umg_merger.sv
module umg_merger
   import umg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [IDX_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_base,
   input  logic              pend_valid,
   input  logic [IDX_W-1:0]  pend_reg,
   input  logic [DATA_W-1:0] pend_value,
   output logic              busy,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data,
   output logic              st_done,
   output logic              op_abort
);

   localparam int BYTES = DATA_W / 8;
   localparam int OFS_W = $clog2(BYTES);

   if ((DATA_W % 8) != 0 || BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_width
      $error("umg_merger: DATA_W must be a power-of-two count of bytes, at least two");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("umg_merger: ADDR_W too small for the byte offset");
   end

   umg_op_e           op_in, op_q;
   logic              accept, rd_take;
   logic [DATA_W-1:0] base_sel, merged;
   logic [ADDR_W-1:0] addr_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DATA_W-1:0] opnd_q, wdata_q, ld_q;

   assign op_in = umg_op_e'(req_op);

   umg_base_select #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_base (
      .pend_valid (pend_valid),
      .pend_reg   (pend_reg),
      .pend_value (pend_value),
      .tgt_reg    (req_reg),
      .tgt_value  (req_base),
      .base       (base_sel)
   );

   umg_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_store (umg_is_store(op_in)),
      .mem_ack   (mem_ack),
      .mem_err   (mem_err),
      .accept    (accept),
      .rd_take   (rd_take),
      .busy      (busy),
      .rd_en     (mem_rd_en),
      .wr_en     (mem_wr_en),
      .ld_fin    (ld_valid),
      .st_fin    (st_done),
      .abort_fin (op_abort)
   );

   umg_merge #(.DATA_W(DATA_W)) u_merge (
      .op       (op_q),
      .ofs      (ofs_q),
      .mem_word (mem_rdata),
      .opnd     (opnd_q),
      .merged   (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= UMG_LD_LEFT;
         addr_q  <= '0;
         ofs_q   <= '0;
         opnd_q  <= '0;
         wdata_q <= '0;
         ld_q    <= '0;
      end else begin
         if (accept) begin
            op_q   <= op_in;
            addr_q <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            ofs_q  <= req_addr[OFS_W-1:0];
            opnd_q <= umg_is_store(op_in) ? req_data : base_sel;
         end
         if (rd_take) begin
            if (umg_is_store(op_q)) wdata_q <= merged;
            else                    ld_q    <= merged;
         end
      end
   end

   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign ld_data   = ld_q;

   assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_en) |-> $past(mem_rd_en && mem_ack && !mem_err));

   assert_write_same_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_en) |-> (mem_addr == $past(mem_addr)));

   assert_abort_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      op_abort |-> ($past(mem_err) && !mem_wr_en && !ld_valid));

   assert_strobe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd_en || mem_wr_en) && !mem_ack && !mem_err) |=>
      ((mem_rd_en || mem_wr_en) && $stable(mem_addr)));

   assert_pending_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_op[1] && pend_valid && (pend_reg == req_reg)) |=>
      (opnd_q == $past(pend_value)));

endmodule

// File: tb/umg_merger_tb_top.sv
module umg_merger_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [31:0] req_addr = '0;
   logic [31:0] req_data = '0;
   logic [4:0]  req_reg = '0;
   logic [31:0] req_base = '0;
   logic        pend_valid = 1'b0;
   logic [4:0]  pend_reg = '0;
   logic [31:0] pend_value = '0;
   logic        busy, mem_rd_en, mem_wr_en, ld_valid, st_done, op_abort;
   logic [31:0] mem_addr, mem_wdata, ld_data;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;

   always #5 clk = ~clk;

   umg_merger dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .req_reg(req_reg),
      .req_base(req_base), .pend_valid(pend_valid), .pend_reg(pend_reg),
      .pend_value(pend_value), .busy(busy), .mem_rd_en(mem_rd_en),
      .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .ld_valid(ld_valid), .ld_data(ld_data), .st_done(st_done),
      .op_abort(op_abort)
   );

   // memory model: one-cycle acknowledge, optional read error
   logic [31:0] mem [16];
   logic [31:0] shadow [16];
   logic        inj_err = 1'b0;
   int          n_rd = 0, n_wr = 0, cyc = 0;
   logic [31:0] last_addr = '0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_err <= 1'b0;
      end else begin
         mem_ack <= 1'b0;
         mem_err <= 1'b0;
         if ((mem_rd_en || mem_wr_en) && !mem_ack && !mem_err) begin
            last_addr <= mem_addr;
            if (mem_rd_en && inj_err) begin
               mem_err <= 1'b1;
            end else begin
               mem_ack <= 1'b1;
               if (mem_rd_en) begin
                  mem_rdata <= mem[mem_addr[5:2]];
                  n_rd <= n_rd + 1;
               end
               if (mem_wr_en) begin
                  mem[mem_addr[5:2]] <= mem_wdata;
                  n_wr <= n_wr + 1;
               end
            end
         end
      end
   end

   // scoreboard
   typedef struct {
      int          kind;      // 0 load, 1 store, 2 abort
      logic [31:0] exp;
      logic [31:0] waddr;
      int          acc;
      int          lat;
      int          rd0;
      int          wr0;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_tests = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_merge(input logic [1:0] op, input logic [1:0] ofs,
                                             input logic [31:0] m, input logic [31:0] r);
      logic [1:0] k;
      k = 2'd3 - ofs;
      case (op)
         2'b00: case (k)
            2'd0: return m;
            2'd1: return (r & 32'h000000ff) | (m << 8);
            2'd2: return (r & 32'h0000ffff) | (m << 16);
            default: return (r & 32'h00ffffff) | (m << 24);
         endcase
         2'b01: case (k)
            2'd0: return (r & 32'hffffff00) | (m >> 24);
            2'd1: return (r & 32'hffff0000) | (m >> 16);
            2'd2: return (r & 32'hff000000) | (m >> 8);
            default: return m;
         endcase
         2'b10: case (k)
            2'd0: return r;
            2'd1: return (m & 32'hff000000) | (r >> 8);
            2'd2: return (m & 32'hffff0000) | (r >> 16);
            default: return (m & 32'hffffff00) | (r >> 24);
         endcase
         default: case (k)
            2'd0: return (m & 32'h00ffffff) | (r << 24);
            2'd1: return (m & 32'h0000ffff) | (r << 16);
            2'd2: return (m & 32'h000000ff) | (r << 8);
            default: return r;
         endcase
      endcase
   endfunction

   task automatic do_op(input logic [1:0] op, input logic [31:0] addr,
                        input logic [31:0] data, input logic [4:0] rg,
                        input logic [31:0] base, input bit pv,
                        input logic [4:0] preg, input logic [31:0] pval,
                        input bit err, input bit poke, input string tag);
      item_t it;
      logic [31:0] opnd;
      @(negedge clk);
      while (busy) @(negedge clk);
      inj_err = err;
      opnd = op[1] ? data : ((pv && preg == rg) ? pval : base);
      it.exp   = exp_merge(op, addr[1:0], shadow[addr[5:2]], opnd);
      it.waddr = {addr[31:2], 2'b00};
      it.kind  = err ? 2 : (op[1] ? 1 : 0);
      it.lat   = (it.kind == 1) ? 4 : 2;
      it.tag   = tag;
      if (it.kind == 1) shadow[addr[5:2]] = it.exp;
      req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data;
      req_reg = rg; req_base = base; pend_valid = pv; pend_reg = preg; pend_value = pval;
      @(negedge clk);
      it.acc = cyc; it.rd0 = n_rd; it.wr0 = n_wr;
      q.push_back(it);
      if (poke) begin
         req_op = 2'b10; req_addr = 32'h38; req_data = 32'hdeadbeef;
         @(negedge clk);
      end
      req_valid = 1'b0; pend_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && (ld_valid || st_done || op_abort)) begin
         item_t it;
         int kind;
         kind = op_abort ? 2 : (st_done ? 1 : 0);
         if (q.size() == 0) begin
            chk(1'b0, "R9", "unexpected result", 32'(kind), 32'hffffffff);
         end else begin
            it = q.pop_front();
            chk(kind == it.kind, "R9", "result kind", 32'(kind), 32'(it.kind));
            chk(cyc - it.acc == it.lat, "R9", "latency", 32'(cyc - it.acc), 32'(it.lat));
            chk(last_addr == it.waddr, "R1", "aligned address", last_addr, it.waddr);
            if (it.kind == 0) begin
               chk(ld_data == it.exp, it.tag, "load data", ld_data, it.exp);
               chk(n_rd - it.rd0 == 1 && n_wr == it.wr0, "R7", "load access count",
                   32'(n_wr - it.wr0), 32'd0);
            end else if (it.kind == 1) begin
               chk(mem[it.waddr[5:2]] == it.exp, it.tag, "stored word",
                   mem[it.waddr[5:2]], it.exp);
               chk(n_rd - it.rd0 == 1 && n_wr - it.wr0 == 1, "R7", "store access count",
                   32'(n_wr - it.wr0), 32'd1);
            end else begin
               chk(n_wr == it.wr0, "R8", "write after read error", 32'(n_wr - it.wr0), 32'd0);
               chk(mem[it.waddr[5:2]] == shadow[it.waddr[5:2]], "R8", "word after abort",
                   mem[it.waddr[5:2]], shadow[it.waddr[5:2]]);
            end
         end
      end
   end

   task automatic finish_up;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i]    = 32'h8899aabb ^ (32'(i) * 32'h01030507);
         shadow[i] = mem[i];
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !mem_rd_en && !mem_wr_en && !ld_valid && !st_done && !op_abort,
          "R10", "outputs in reset", {26'd0, busy, mem_rd_en, mem_wr_en, ld_valid, st_done, op_abort}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_rd_en && !mem_wr_en, "R10", "idle after reset",
          {29'd0, busy, mem_rd_en, mem_wr_en}, 32'd0);

      for (int o = 0; o < 4; o++)
         do_op(2'b00, 32'h08 + 32'(o), 0, 5'd3, 32'h11223344, 0, 0, 0, 0, 0, "R2");
      for (int o = 0; o < 4; o++)
         do_op(2'b01, 32'h0c + 32'(o), 0, 5'd4, 32'hcafef00d, 0, 0, 0, 0, 0, "R3");
      for (int o = 0; o < 4; o++)
         do_op(2'b10, 32'h10 + 32'(4 * o + o), 32'h12345678, 0, 0, 0, 0, 0, 0, 0, "R4");
      for (int o = 0; o < 4; o++)
         do_op(2'b11, 32'h20 + 32'(4 * o + o), 32'h9abcdef0, 0, 0, 0, 0, 0, 0, 0, "R5");
      // second pass on the same word: merge against previously merged contents
      do_op(2'b11, 32'h21, 32'h55667788, 0, 0, 0, 0, 0, 0, 0, "R5");
      do_op(2'b10, 32'h22, 32'h0f0e0d0c, 0, 0, 0, 0, 0, 0, 0, "R4");
      // base selection with a pending delayed load
      do_op(2'b00, 32'h09, 0, 5'd7, 32'h11111111, 1, 5'd7, 32'habcdef01, 0, 0, "R6");
      do_op(2'b01, 32'h0a, 0, 5'd7, 32'h22222222, 1, 5'd8, 32'habcdef01, 0, 0, "R6");
      do_op(2'b00, 32'h0b, 0, 5'd9, 32'h33333333, 0, 5'd9, 32'h44444444, 0, 0, "R6");
      // read error on a store, and on a load
      do_op(2'b10, 32'h31, 32'hffffffff, 0, 0, 0, 0, 0, 1, 0, "R8");
      do_op(2'b01, 32'h31, 0, 5'd2, 32'h0, 0, 0, 0, 1, 0, "R8");
      // request while busy must be dropped
      do_op(2'b11, 32'h35, 32'h01020304, 0, 0, 0, 0, 0, 0, 1, "R9");
      do_op(2'b00, 32'h37, 0, 5'd1, 32'h76543210, 0, 0, 0, 0, 0, "R2");

      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(mem[14] == shadow[14], "R9", "word hit by request while busy", mem[14], shadow[14]);
      chk(q.size() == 0, "R9", "results outstanding", 32'(q.size()), 32'd0);
      finish_up();
   end

endmodule